// File: doc/BRIEF.md
# Port Interrupt Status and Enable Logic

This block holds the interrupt status and interrupt enable registers of one port of a serial storage host controller, together with a small diagnostic register that two of the status bits depend on. Upstream logic reports completed protocol events as one-cycle strobes, such as a received device-to-host register frame, a PIO setup, a DMA setup, set-device-bits or a processed descriptor. Each strobe sets a sticky status bit. Software reads the bits through a simple register port and clears them by writing 1.

Two status bits cannot be cleared in the status register. The connect-change bit always follows a diagnostic flag. The unknown-frame bit is set only once the frame has been posted to memory, and it is cleared when software clears the matching diagnostic flag. An interlock-change bit exists only when a configuration input says that interlock switches are fitted. The enable register masks which active sources reach the port interrupt. Two further enables pass level error flags from elsewhere in the port: a task-file error and a host-bus fatal error. A global interrupt enable gates the registered interrupt output.

Top module: `pis_port_irq`

## Requirements
- R1: A one-cycle strobe on `ev_d2h`, `ev_pio`, `ev_dma`, `ev_sdb` or `ev_desc` sets status bit 0, 1, 2, 3 or 5 respectively. The status register is at address 0 and the bit reads 1 from the next cycle onward.
- R2: A write to address 0 clears each status bit 0, 1, 2, 3, 5 and 7 whose data bit is 1. Data bits that are 0 leave the status bits unchanged.
- R3: When a set strobe and a write-1 clear hit the same status bit in the same cycle, the bit reads 1 afterwards.
- R4: A status bit whose enable bit is 0 is still set and held by its event, and `port_irq` stays 0 because of it.
- R5: `port_irq` is 1 in the cycle after one where `glb_ie` is 1 and some enabled source is active. It is 0 in the cycle after one where `glb_ie` is 0.
- R6: Status bit 6 (connect change) always equals diagnostic bit 1 (address 2). Writing it at address 0 has no effect. It clears only when software writes 1 to diagnostic bit 1.
- R7: Status bit 4 (unknown frame) is set by `ev_ufrm_post` and not by `diag_set_f`. It clears when software writes 1 to diagnostic bit 0. If a post strobe falls in the same cycle as that write, the bit stays set.
- R8: Status bit 7 (interlock change) is set by `ev_ilock` only while `ilock_supported` is 1. It reads 0 from the cycle after `ilock_supported` is 0.
- R9: After reset, status, enable and diagnostic registers read 0. Enable bits 0 to 9 at address 1 are read/write. Enable bit 10 (cold presence) always reads 0.
- R10: A task-file error interrupt needs enable bit 8, `tf_err` and `glb_ie` all at 1. A host-bus fatal interrupt needs enable bit 9, `hbf_err` and `glb_ie` all at 1.
- R11: Reserved bits read 0 and ignore writes: status bits 8 to 31, enable bits 10 to 31, diagnostic bits 2 to 31, and all of address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 enable, 2 diagnostic, 3 reserved) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_d2h | input | 1 | Device-to-host register frame event |
| ev_pio | input | 1 | PIO setup event |
| ev_dma | input | 1 | DMA setup event |
| ev_sdb | input | 1 | Set-device-bits event |
| ev_desc | input | 1 | Descriptor processed event |
| ev_ufrm_post | input | 1 | Unknown frame posted to memory |
| ev_ilock | input | 1 | Interlock switch changed |
| diag_set_x | input | 1 | Sets diagnostic connect-change flag |
| diag_set_f | input | 1 | Sets diagnostic unknown-frame flag |
| tf_err | input | 1 | Task-file error flag (level) |
| hbf_err | input | 1 | Host-bus fatal error flag (level) |
| ilock_supported | input | 1 | Interlock switches fitted |
| glb_ie | input | 1 | Global interrupt enable |
| port_irq | output | 1 | Registered port interrupt |

## Verification
A hardware set strobe and a software write-1 clear can land on the same status bit in the same cycle. The same holds for the unknown-frame post and a diagnostic clear. The bench drives the strobe and the register write on the same falling edge, so both are sampled on one rising edge, and then reads the bit back: it must still be 1. The other race is between an enable write and the registered interrupt. That one is judged by sampling `port_irq` exactly one edge after the enable lands.

// File: rtl/pis_pkg.sv
package pis_pkg;

    localparam int DW     = 32;
    localparam int AW     = 2;

    // status / enable bit positions
    localparam int B_D2H  = 0;
    localparam int B_PIO  = 1;
    localparam int B_DMA  = 2;
    localparam int B_SDB  = 3;
    localparam int B_UFRM = 4;
    localparam int B_DESC = 5;
    localparam int B_CONN = 6;
    localparam int B_ILCK = 7;
    localparam int B_TFE  = 8;
    localparam int B_HBF  = 9;
    localparam int B_CPD  = 10;
    localparam int NSTAT  = 8;   // status bits 0..7
    localparam int NEN    = 10;  // writable enable bits 0..9

    // diagnostic bit positions
    localparam int DG_F   = 0;
    localparam int DG_X   = 1;
    localparam int NDIAG  = 2;

    // plain write-1-clear bank
    localparam int NPLAIN = 6;

    typedef enum logic [AW-1:0] {
        A_STAT = 2'd0,
        A_EN   = 2'd1,
        A_DIAG = 2'd2,
        A_RSVD = 2'd3
    } addr_e;

    typedef struct packed {
        logic ilock;
        logic desc;
        logic sdb;
        logic dma;
        logic pio;
        logic d2h;
    } plain_ev_t;

    // map a plain-bank index to its status bit position
    function automatic int plain_pos(input int idx);
        case (idx)
            0: return B_D2H;
            1: return B_PIO;
            2: return B_DMA;
            3: return B_SDB;
            4: return B_DESC;
            default: return B_ILCK;
        endcase
    endfunction

    function automatic logic [DW-1:0] low_mask(input int n);
        logic [DW-1:0] m;
        for (int i = 0; i < DW; i++) m[i] = (i < n);
        return m;
    endfunction

endpackage

// File: rtl/pis_w1c_bank.sv
module pis_w1c_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] keep,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else
                q[i] <= (set[i] | (q[i] & ~clr[i])) & keep[i];
        end
    end
endmodule

// File: rtl/pis_enable_reg.sv
module pis_enable_reg
    import pis_pkg::*;
#(
    parameter int W = NEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [W-1:0]  en_q
);
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (we)
            en_q <= wdata[W-1:0];
    end
endmodule

// File: rtl/pis_irq_agg.sv
module pis_irq_agg
    import pis_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSTAT-1:0] stat,
    input  logic [NEN-1:0]   en,
    input  logic             tf_err,
    input  logic             hbf_err,
    input  logic             glb_ie,
    output logic             irq_q
);
    logic [NEN-1:0] src;

    always_comb begin
        src[NSTAT-1:0] = stat & en[NSTAT-1:0];
        src[B_TFE]     = tf_err  & en[B_TFE];
        src[B_HBF]     = hbf_err & en[B_HBF];
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= glb_ie & (|src);
    end
endmodule

// File: rtl/pis_port_irq.sv
module pis_port_irq
    import pis_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          ev_d2h,
    input  logic          ev_pio,
    input  logic          ev_dma,
    input  logic          ev_sdb,
    input  logic          ev_desc,
    input  logic          ev_ufrm_post,
    input  logic          ev_ilock,
    input  logic          diag_set_x,
    input  logic          diag_set_f,
    input  logic          tf_err,
    input  logic          hbf_err,
    input  logic          ilock_supported,
    input  logic          glb_ie,
    output logic          port_irq
);
    addr_e            sel;
    logic             wr_stat, wr_en, wr_diag;
    plain_ev_t        pev;
    logic [NPLAIN-1:0] p_set, p_clr, p_keep, p_q;
    logic [NDIAG-1:0] d_set, d_clr, d_q;
    logic             ufrm_q, f_sw_clr;
    logic [NSTAT-1:0] stat_vec;
    logic [NEN-1:0]   en_q;

    assign sel     = addr_e'(reg_addr);
    assign wr_stat = reg_wr && (sel == A_STAT);
    assign wr_en   = reg_wr && (sel == A_EN);
    assign wr_diag = reg_wr && (sel == A_DIAG);

    assign pev = '{ilock: ev_ilock, desc: ev_desc, sdb: ev_sdb,
                   dma: ev_dma, pio: ev_pio, d2h: ev_d2h};

    // plain write-1-clear status bits
    for (genvar i = 0; i < NPLAIN; i++) begin : g_plain
        localparam int POS = plain_pos(i);
        assign p_set[i]  = pev[i];
        assign p_clr[i]  = wr_stat & reg_wdata[POS];
        assign p_keep[i] = (POS == B_ILCK) ? ilock_supported : 1'b1;
        assign stat_vec[POS] = p_q[i];
    end

    pis_w1c_bank #(.N(NPLAIN)) i_plain (
        .clk (clk), .rst (rst), .set (p_set), .clr (p_clr),
        .keep(p_keep), .q (p_q)
    );

    // diagnostic flags
    assign d_set[DG_F] = diag_set_f;
    assign d_set[DG_X] = diag_set_x;
    assign d_clr       = {NDIAG{wr_diag}} & reg_wdata[NDIAG-1:0];

    pis_w1c_bank #(.N(NDIAG)) i_diag (
        .clk (clk), .rst (rst), .set (d_set), .clr (d_clr),
        .keep({NDIAG{1'b1}}), .q (d_q)
    );

    // unknown-frame: set on post, cleared by software clearing diag F
    assign f_sw_clr = d_clr[DG_F];

    always_ff @(posedge clk) begin
        if (rst)
            ufrm_q <= 1'b0;
        else if (ev_ufrm_post)
            ufrm_q <= 1'b1;
        else if (f_sw_clr)
            ufrm_q <= 1'b0;
    end

    assign stat_vec[B_UFRM] = ufrm_q;
    assign stat_vec[B_CONN] = d_q[DG_X];

    pis_enable_reg #(.W(NEN)) i_en (
        .clk (clk), .rst (rst), .we (wr_en), .wdata (reg_wdata), .en_q (en_q)
    );

    pis_irq_agg i_agg (
        .clk (clk), .rst (rst), .stat (stat_vec), .en (en_q),
        .tf_err (tf_err), .hbf_err (hbf_err), .glb_ie (glb_ie),
        .irq_q (port_irq)
    );

    // read mux; reserved bits and the cold-presence enable read 0
    always_comb begin
        reg_rdata = '0;
        case (sel)
            A_STAT: reg_rdata[NSTAT-1:0] = stat_vec;
            A_EN:   reg_rdata[NEN-1:0]   = en_q;
            A_DIAG: reg_rdata[NDIAG-1:0] = d_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pis_port_irq_chk.sv
module pis_port_irq_chk
    import pis_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ev_d2h,
    input logic             ev_pio,
    input logic             ev_ufrm_post,
    input logic             diag_set_x,
    input logic             ilock_supported,
    input logic             glb_ie,
    input logic             port_irq,
    input logic [NSTAT-1:0] stat_vec
);
    p_d2h_sets_r1: assert property (@(posedge clk) disable iff (rst)
        ev_d2h |=> stat_vec[B_D2H]);

    p_pio_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
        ev_pio |=> stat_vec[B_PIO]);

    p_irq_gated_r5: assert property (@(posedge clk) disable iff (rst)
        !glb_ie |=> !port_irq);

    p_conn_follows_r6: assert property (@(posedge clk) disable iff (rst)
        diag_set_x |=> stat_vec[B_CONN]);

    p_ufrm_post_r7: assert property (@(posedge clk) disable iff (rst)
        ev_ufrm_post |=> stat_vec[B_UFRM]);

    p_ilock_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !ilock_supported |=> !stat_vec[B_ILCK]);
endmodule

bind pis_port_irq pis_port_irq_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .ev_d2h         (ev_d2h),
    .ev_pio         (ev_pio),
    .ev_ufrm_post   (ev_ufrm_post),
    .diag_set_x     (diag_set_x),
    .ilock_supported(ilock_supported),
    .glb_ie         (glb_ie),
    .port_irq       (port_irq),
    .stat_vec       (stat_vec)
);

// File: tb/test_pis_port_irq.sv
module test_pis_port_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic ev_d2h = 0, ev_pio = 0, ev_dma = 0, ev_sdb = 0, ev_desc = 0;
    logic ev_ufrm_post = 0, ev_ilock = 0, diag_set_x = 0, diag_set_f = 0;
    logic tf_err = 0, hbf_err = 0, ilock_supported = 1, glb_ie = 0;
    logic port_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pis_port_irq i_pis_port_irq (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_d2h(ev_d2h), .ev_pio(ev_pio), .ev_dma(ev_dma), .ev_sdb(ev_sdb),
        .ev_desc(ev_desc), .ev_ufrm_post(ev_ufrm_post), .ev_ilock(ev_ilock),
        .diag_set_x(diag_set_x), .diag_set_f(diag_set_f),
        .tf_err(tf_err), .hbf_err(hbf_err), .ilock_supported(ilock_supported),
        .glb_ie(glb_ie), .port_irq(port_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk("R9 status reset", v, 32'h0);
        rd(2'd1, v); chk("R9 enable reset", v, 32'h0);
        rd(2'd2, v); chk("R9 diag reset", v, 32'h0);
        chk("R9 irq reset", {31'd0, port_irq}, 32'h0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        ev_d2h = 1; ev_pio = 1; step(); ev_d2h = 0; ev_pio = 0;
        ev_dma = 1; ev_sdb = 1; ev_desc = 1; step();
        ev_dma = 0; ev_sdb = 0; ev_desc = 0;
        rd(2'd0, v); chk("R1 event bits set", v, 32'h2F);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R2 write zero keeps bits", v, 32'h2F);
        wr(2'd0, 32'h5);
        rd(2'd0, v); chk("R2 partial clear", v, 32'h2A);
        wr(2'd0, 32'h2A);
        rd(2'd0, v); chk("R2 full clear", v, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        ev_dma = 1; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'h4;
        step();
        ev_dma = 0; reg_wr = 0; reg_wdata = '0;
        rd(2'd0, v); chk("R3 set beats clear", v, 32'h4);
        wr(2'd0, 32'h4);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        glb_ie = 1;
        ev_d2h = 1; step(); ev_d2h = 0;
        step();
        rd(2'd0, v); chk("R4 masked bit still set", v, 32'h1);
        chk("R4 masked no irq", {31'd0, port_irq}, 32'h0);
        wr(2'd1, 32'h1);
        step();
        chk("R5 enabled irq", {31'd0, port_irq}, 32'h1);
        glb_ie = 0; step();
        chk("R5 global gate", {31'd0, port_irq}, 32'h0);
        wr(2'd1, 32'h0); wr(2'd0, 32'h1);
    endtask

    task automatic t_conn();
        logic [31:0] v;
        diag_set_x = 1; step(); diag_set_x = 0;
        rd(2'd0, v); chk("R6 conn mirrors diag X", v, 32'h40);
        wr(2'd0, 32'h40);
        rd(2'd0, v); chk("R6 status write ignored", v, 32'h40);
        wr(2'd2, 32'h2);
        rd(2'd0, v); chk("R6 cleared via diag", v, 32'h0);
    endtask

    task automatic t_ufrm();
        logic [31:0] v;
        diag_set_f = 1; step(); diag_set_f = 0;
        rd(2'd0, v); chk("R7 detection does not set", v, 32'h0);
        rd(2'd2, v); chk("R7 diag F set", v, 32'h1);
        ev_ufrm_post = 1; step(); ev_ufrm_post = 0;
        rd(2'd0, v); chk("R7 post sets", v, 32'h10);
        wr(2'd0, 32'h10);
        rd(2'd0, v); chk("R7 status write ignored", v, 32'h10);
        wr(2'd2, 32'h1);
        rd(2'd0, v); chk("R7 cleared with diag F", v, 32'h0);
        ev_ufrm_post = 1; reg_wr = 1; reg_addr = 2'd2; reg_wdata = 32'h1;
        step();
        ev_ufrm_post = 0; reg_wr = 0; reg_wdata = '0;
        rd(2'd0, v); chk("R7 post beats diag clear", v, 32'h10);
        wr(2'd2, 32'h1);
    endtask

    task automatic t_ilock();
        logic [31:0] v;
        ev_ilock = 1; step(); ev_ilock = 0;
        rd(2'd0, v); chk("R8 interlock set when supported", v, 32'h80);
        ilock_supported = 0; step();
        rd(2'd0, v); chk("R8 forced zero", v, 32'h0);
        ev_ilock = 1; step(); ev_ilock = 0;
        rd(2'd0, v); chk("R8 unsupported ignores event", v, 32'h0);
        ilock_supported = 1;
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R9 enable rw, cold presence 0", v, 32'h3FF);
        wr(2'd1, 32'h0);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); chk("R11 reserved address", v, 32'h0);
        wr(2'd2, 32'hFFFF_FFFC);
        rd(2'd2, v); chk("R11 diag reserved bits", v, 32'h0);
        wr(2'd0, 32'hFFFF_FF00);
        rd(2'd0, v); chk("R11 status reserved bits", v, 32'h0);
    endtask

    task automatic t_errs();
        glb_ie = 1;
        wr(2'd1, 32'h100);
        step();
        chk("R10 tfe without flag", {31'd0, port_irq}, 32'h0);
        tf_err = 1; step();
        chk("R10 tfe irq", {31'd0, port_irq}, 32'h1);
        tf_err = 0; hbf_err = 1; step();
        chk("R10 hbf masked", {31'd0, port_irq}, 32'h0);
        wr(2'd1, 32'h200);
        step();
        chk("R10 hbf irq", {31'd0, port_irq}, 32'h1);
        hbf_err = 0; glb_ie = 0;
        wr(2'd1, 32'h0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_events();
        t_collide();
        t_mask();
        t_conn();
        t_ufrm();
        t_ilock();
        t_regs();
        t_errs();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule